// File: doc/BRIEF.md
# Self-Advancing Indirect User-Bit Buffer

This block keeps the user bits recovered from an incoming S/PDIF stream in a small byte buffer (24 bytes by default). A user-bit assembler upstream packs the serial bits into bytes and writes each byte at an explicit index. The block raises a filled flag once the last byte of the programmed length has arrived.

The host never sees the buffer through a direct address window. It programs a byte offset into a pointer register and then reads a single data register. Each read of that register returns the byte at the current offset, and the pointer then moves one step forward. The usual sequence is to write 0 to the pointer and read the data register once per byte until the buffer is drained. The usable length of the buffer is set through a length register, and the pointer wraps back to 0 at the end of that length.

The host side has separate read and write addresses, so a pointer write and a data read can fall in the same cycle.

Top module: `userbit_ibuf`

## Requirements
- R1: After reset the pointer reads 0, the length reads 24, the filled flag is 0, and every buffer byte is 0x00.
- R2: Reading address 0x51 returns the buffer byte at the current pointer on `host_rdata` in the same cycle. The value comes from the pointer as it stood before the clock edge.
- R3: Each cycle with a read of 0x51 moves the pointer forward by one on the next clock edge. From length minus 1 it goes to 0 instead.
- R4: A write to the pointer register at 0x50 loads the pointer. If a read of 0x51 happens in the same cycle, the write wins over the advance.
- R5: A pointer write at or above the current length loads length minus 1.
- R6: A write to 0x52 sets the length. A value of 0 gives 1, and a value above 24 gives 24. If the resulting pointer is not below the new length, the pointer becomes 0. Reading 0x52 returns the length.
- R7: An assembler write stores `asm_data` at index `asm_idx` when that index is below 24. Indices of 24 and above change no byte.
- R8: An assembler write at index length minus 1 sets the filled flag on the next edge. The flag is visible at bit 0 of address 0x53 and on `buf_full`.
- R9: Writing 0x53 with bit 0 set clears the filled flag, and writing it with bit 0 clear has no effect. If the flag is set in the same cycle as a clear, the set wins.
- R10: Reading the pointer register (0x50) returns the pointer. Reads of any address other than 0x51 leave the pointer unchanged, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_waddr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host register read strobe |
| host_raddr | input | 8 | Host read address |
| host_rdata | output | 8 | Combinational read data |
| asm_wr | input | 1 | Assembler byte write strobe |
| asm_idx | input | 5 | Assembler byte index |
| asm_data | input | 8 | Assembler byte |
| buf_full | output | 1 | Filled flag |

## Verification
The assertions assume that reset is synchronous and that every input holds a known value from the first clock edge onward. They also assume that the host can present only one write address per cycle, which the port structure guarantees. The assembler index may take any value, including values beyond the buffer.

The bench drives all strobes low between operations and changes inputs only half a cycle away from the sampling edge. It deliberately covers the cases the properties guard:
- writes beyond the length,
- lengths of 0 and above 24,
- an assembler index past the end,
- a set and a clear of the filled flag in the same cycle.

// File: rtl/ubuf_pkg.sv
`timescale 1ns/1ps
package ubuf_pkg;

    localparam int unsigned BUF_DEPTH = 24;
    localparam int unsigned BYTE_W    = 8;

    localparam logic [7:0] ADDR_PTR  = 8'h50;
    localparam logic [7:0] ADDR_DATA = 8'h51;
    localparam logic [7:0] ADDR_LEN  = 8'h52;
    localparam logic [7:0] ADDR_STAT = 8'h53;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PTR,
        SEL_DATA,
        SEL_LEN,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic       ptr_wr;
        logic       len_wr;
        logic       flag_clr;
        logic       data_rd;
        logic [7:0] wdata;
    } host_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADDR_PTR:  return SEL_PTR;
            ADDR_DATA: return SEL_DATA;
            ADDR_LEN:  return SEL_LEN;
            ADDR_STAT: return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ubuf_ptr.sv
`timescale 1ns/1ps
module ubuf_ptr
    import ubuf_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  host_cmd_t     cmd,
    output logic [IW-1:0] ptr_q,
    output logic [IW-1:0] len_q
);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);

    logic [IW-1:0] last_idx;
    logic [IW-1:0] len_nx;
    logic [IW-1:0] ptr_nx;

    assign last_idx = len_q - IW'(1);

    always_comb begin
        len_nx = len_q;
        if (cmd.len_wr) begin
            if (cmd.wdata == 8'h00)
                len_nx = IW'(1);
            else if (cmd.wdata > DEPTH_B)
                len_nx = IW'(DEPTH);
            else
                len_nx = cmd.wdata[IW-1:0];
        end
    end

    always_comb begin
        ptr_nx = ptr_q;
        if (cmd.ptr_wr)
            ptr_nx = (cmd.wdata > 8'(last_idx)) ? last_idx : cmd.wdata[IW-1:0];
        else if (cmd.data_rd)
            ptr_nx = (ptr_q == last_idx) ? '0 : ptr_q + IW'(1);
        if (cmd.len_wr && (ptr_nx >= len_nx))
            ptr_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            len_q <= IW'(DEPTH);
        end else begin
            ptr_q <= ptr_nx;
            len_q <= len_nx;
        end
    end
endmodule

// File: rtl/ubuf_store.sv
`timescale 1ns/1ps
module ubuf_store #(
    parameter int DEPTH = 24,
    parameter int DW    = 8,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                cells[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == IW'(i))
                rd_data = cells[i];
    end
endmodule

// File: rtl/ubuf_flag.sv
`timescale 1ns/1ps
module ubuf_flag #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          asm_wr,
    input  logic [IW-1:0] asm_idx,
    input  logic [IW-1:0] len_q,
    input  logic          clr,
    output logic          filled_q
);
    logic hit_last;

    assign hit_last = asm_wr && (asm_idx == (len_q - IW'(1)));

    always_ff @(posedge clk) begin
        if (rst)
            filled_q <= 1'b0;
        else if (hit_last)
            filled_q <= 1'b1;
        else if (clr)
            filled_q <= 1'b0;
    end
endmodule

// File: rtl/userbit_ibuf.sv
`timescale 1ns/1ps
module userbit_ibuf
    import ubuf_pkg::*;
#(
    parameter int DEPTH = ubuf_pkg::BUF_DEPTH,
    parameter int DW    = ubuf_pkg::BYTE_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_wr,
    input  logic [7:0]                   host_waddr,
    input  logic [7:0]                   host_wdata,
    input  logic                         host_rd,
    input  logic [7:0]                   host_raddr,
    output logic [DW-1:0]                host_rdata,
    input  logic                         asm_wr,
    input  logic [$clog2(DEPTH+1)-1:0]   asm_idx,
    input  logic [DW-1:0]                asm_data,
    output logic                         buf_full
);
    localparam int IW = $clog2(DEPTH + 1);

    reg_sel_e      wsel;
    reg_sel_e      rsel;
    host_cmd_t     cmd;
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] len_q;
    logic          filled_q;
    logic [DW-1:0] rd_byte;

    assign wsel = decode_addr(host_waddr);
    assign rsel = decode_addr(host_raddr);

    always_comb begin
        cmd.ptr_wr   = host_wr && (wsel == SEL_PTR);
        cmd.len_wr   = host_wr && (wsel == SEL_LEN);
        cmd.flag_clr = host_wr && (wsel == SEL_STAT) && host_wdata[0];
        cmd.data_rd  = host_rd && (rsel == SEL_DATA);
        cmd.wdata    = host_wdata;
    end

    ubuf_ptr #(.DEPTH(DEPTH), .IW(IW)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .ptr_q (ptr_q),
        .len_q (len_q)
    );

    ubuf_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (asm_wr),
        .wr_idx  (asm_idx),
        .wr_data (asm_data),
        .rd_idx  (ptr_q),
        .rd_data (rd_byte)
    );

    ubuf_flag #(.IW(IW)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .asm_wr   (asm_wr),
        .asm_idx  (asm_idx),
        .len_q    (len_q),
        .clr      (cmd.flag_clr),
        .filled_q (filled_q)
    );

    always_comb begin
        case (rsel)
            SEL_PTR:  host_rdata = DW'(ptr_q);
            SEL_DATA: host_rdata = rd_byte;
            SEL_LEN:  host_rdata = DW'(len_q);
            SEL_STAT: host_rdata = DW'(filled_q);
            default:  host_rdata = '0;
        endcase
    end

    assign buf_full = filled_q;
endmodule

// File: rtl/ubuf_chk.sv
`timescale 1ns/1ps
module ubuf_chk #(
    parameter int DEPTH = 24,
    parameter int IW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic [7:0]    host_waddr,
    input logic [7:0]    host_wdata,
    input logic          host_rd,
    input logic [7:0]    host_raddr,
    input logic          asm_wr,
    input logic [IW-1:0] asm_idx,
    input logic [IW-1:0] ptr_q,
    input logic [IW-1:0] len_q,
    input logic          filled_q
);
    logic data_rd;
    logic ptr_wr;
    logic len_wr;
    logic set_hit;

    assign data_rd = host_rd && (host_raddr == 8'h51);
    assign ptr_wr  = host_wr && (host_waddr == 8'h50);
    assign len_wr  = host_wr && (host_waddr == 8'h52);
    assign set_hit = asm_wr && (asm_idx == len_q - IW'(1));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ptr_q == '0) && (len_q == IW'(DEPTH)) && !filled_q);

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !ptr_wr && !len_wr && (ptr_q != len_q - IW'(1)))
        |=> ptr_q == $past(ptr_q) + IW'(1));

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !ptr_wr && !len_wr && (ptr_q == len_q - IW'(1)))
        |=> ptr_q == '0);

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_wr && (host_wdata < 8'(len_q)))
        |=> ptr_q == $past(host_wdata[IW-1:0]));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q < len_q);

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0) && (len_q <= IW'(DEPTH)));

    // R8
    fill_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> filled_q);

    // R9
    fill_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && (host_waddr == 8'h53) && host_wdata[0] && !set_hit)
        |=> !filled_q);

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_rd && !ptr_wr && !len_wr) |=> $stable(ptr_q));
endmodule

bind userbit_ibuf ubuf_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_waddr (host_waddr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .host_raddr (host_raddr),
    .asm_wr     (asm_wr),
    .asm_idx    (asm_idx),
    .ptr_q      (ptr_q),
    .len_q      (len_q),
    .filled_q   (filled_q)
);

// File: tb/userbit_ibuf_test.sv
`timescale 1ns/1ps
module userbit_ibuf_test;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_waddr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] host_raddr = 8'h00;
    logic [7:0] host_rdata;
    logic       asm_wr = 1'b0;
    logic [4:0] asm_idx = 5'd0;
    logic [7:0] asm_data = 8'h00;
    logic       buf_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    userbit_ibuf uut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_waddr (host_waddr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .host_raddr (host_raddr),
        .host_rdata (host_rdata),
        .asm_wr     (asm_wr),
        .asm_idx    (asm_idx),
        .asm_data   (asm_data),
        .buf_full   (buf_full)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) + 5);
    endfunction

    task automatic cyc(input logic rd, input logic [7:0] ra, input logic [7:0] exp,
                       input logic wr, input logic [7:0] wa, input logic [7:0] wd,
                       input logic aw, input logic [4:0] ai, input logic [7:0] ad,
                       input string tag);
        sb_item_t it;
        @(negedge clk);
        host_rd = rd; host_raddr = ra;
        host_wr = wr; host_waddr = wa; host_wdata = wd;
        asm_wr = aw; asm_idx = ai; asm_data = ad;
        if (rd) begin
            it.tag = tag;
            it.exp = exp;
            sb_q.push_back(it);
        end
        @(posedge clk);
        #1;
        host_rd = 1'b0; host_wr = 1'b0; asm_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b1, a, exp, 1'b0, 8'h00, 8'h00, 1'b0, 5'd0, 8'h00, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, a, d, 1'b0, 5'd0, 8'h00, "");
    endtask

    task automatic put(input logic [4:0] i, input logic [7:0] d);
        cyc(1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, i, d, "");
    endtask

    task automatic full_is(input logic exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (buf_full !== exp) begin
            errors++;
            $display("FAIL %s: buf_full=%0b expected %0b", tag, buf_full, exp);
        end
    endtask

    // monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        #1;
        if (host_rd) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read rdata=%02h expected none", host_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (host_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata=%02h expected %02h", it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run active=1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(8'h50, 8'h00, "R1 pointer");
        rd(8'h52, 8'd24, "R1 length");
        rd(8'h53, 8'h00, "R1 flag");
        full_is(1'b0, "R1 buf_full");
        rd(8'h51, 8'h00, "R1 byte zero");

        // R7 R8 fill the buffer
        for (int i = 0; i < 23; i++) put(5'(i), pat(i));
        rd(8'h53, 8'h00, "R8 not yet filled");
        put(5'd23, pat(23));
        rd(8'h53, 8'h01, "R8 filled");
        full_is(1'b1, "R8 buf_full");

        // R2 R3 drain with wrap
        wr(8'h50, 8'h00);
        for (int i = 0; i < 24; i++) rd(8'h51, pat(i), "R2 R3 drain");
        rd(8'h51, pat(0), "R3 wrap");

        // R10 pointer read does not move it
        rd(8'h50, 8'h01, "R10 pointer");
        rd(8'h50, 8'h01, "R10 pointer again");

        // R5 clamp
        wr(8'h50, 8'd30);
        rd(8'h50, 8'd23, "R5 clamp");

        // R4 write beats advance
        cyc(1'b1, 8'h51, pat(23), 1'b1, 8'h50, 8'h05, 1'b0, 5'd0, 8'h00, "R4 old byte");
        rd(8'h50, 8'h05, "R4 loaded");

        // R6 shorter length
        wr(8'h52, 8'd8);
        rd(8'h52, 8'd8, "R6 length");
        rd(8'h50, 8'h05, "R6 pointer kept");
        rd(8'h51, pat(5), "R3 short");
        rd(8'h51, pat(6), "R3 short");
        rd(8'h51, pat(7), "R3 short");
        rd(8'h51, pat(0), "R3 short wrap");
        wr(8'h50, 8'd7);
        wr(8'h52, 8'd4);
        rd(8'h50, 8'h00, "R6 pointer reset");
        wr(8'h52, 8'd0);
        rd(8'h52, 8'd1, "R6 zero length");
        wr(8'h52, 8'd40);
        rd(8'h52, 8'd24, "R6 over length");

        // R9 clear behaviour
        wr(8'h53, 8'hFE);
        rd(8'h53, 8'h01, "R9 bit0 clear no effect");
        wr(8'h53, 8'h01);
        rd(8'h53, 8'h00, "R9 cleared");
        full_is(1'b0, "R9 buf_full");
        wr(8'h52, 8'd4);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 8'h53, 8'h01, 1'b1, 5'd3, 8'h33, "");
        rd(8'h53, 8'h01, "R9 set wins");
        full_is(1'b1, "R8 buf_full short");
        wr(8'h53, 8'h01);

        // R7 out of range and mid index
        put(5'd24, 8'hAA);
        rd(8'h53, 8'h00, "R7 far index no flag");
        put(5'd2, 8'h5C);
        rd(8'h53, 8'h00, "R8 mid index no flag");
        rd(8'h51, pat(0), "R7 byte0");
        rd(8'h51, pat(1), "R7 byte1");
        rd(8'h51, 8'h5C, "R7 byte2");
        rd(8'h51, 8'h33, "R7 byte3");
        rd(8'h51, pat(0), "R3 wrap len4");

        // R10 unmapped
        rd(8'h60, 8'h00, "R10 unmapped");
        rd(8'h50, 8'h01, "R10 pointer held");

        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: left=%0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule